// File: doc/BRIEF.md
# Arithmetic Result Flag Generator

This block is a small integer execution unit that pairs a combinational result path with a registered condition-code word. Two operands and a three-bit operation code choose one of five operations: add, subtract, bitwise AND, bitwise OR or bitwise XOR. For every operation the block works out the result and six status bits that describe it. The status bits are carry (a borrow for subtraction), signed overflow, sign, zero, a carry or borrow across the nibble boundary, and even parity of the low byte.

The result and the freshly computed flags appear on the outputs in the same cycle as the inputs. When the valid strobe is high and the code is legal, the flags are also captured into a flag register. Downstream logic can read that register for as long as it likes, until the next valid operation replaces it. Codes 5 to 7 are reserved. They produce a zero result and all-clear flags, and they never load the register. There are no states beyond the flag register itself. Reset clears the register and takes precedence over any load in the same cycle.

Top module: `afg_core`

## Requirements
- R1: `res_out` is `a_in + b_in` for code 0, `a_in - b_in` for code 1, `a_in & b_in` for code 2, `a_in | b_in` for code 3 and `a_in ^ b_in` for code 4, all modulo 2^W.
- R2: Flag bit 0 (carry) is the unsigned carry out of the addition for code 0. For code 1 it is set exactly when unsigned `a_in < b_in`. It is 0 for codes 2 to 4.
- R3: Flag bit 5 (overflow) is set when the two's-complement sum (code 0) or difference (code 1) lies outside the signed W-bit range. It is 0 for codes 2 to 4.
- R4: Flag bit 4 (sign) equals the most significant bit of `res_out` for codes 0 to 4.
- R5: Flag bit 3 (zero) is set exactly when `res_out` is all zeros for codes 0 to 4.
- R6: Flag bit 2 (nibble carry) is set for code 0 when `a_in[3:0] + b_in[3:0] > 15`. For code 1 it is set when `a_in[3:0] < b_in[3:0]`. It is 0 for codes 2 to 4.
- R7: Flag bit 1 (parity) is set when `res_out[7:0]` holds an even number of 1 bits, for codes 0 to 4.
- R8: On a rising clock edge with `op_valid` high and a legal code (0 to 4), `flag_reg` takes the value `flag_now` had before the edge. With `op_valid` low, `flag_reg` keeps its value.
- R9: An asserted `rst_n` (low) clears `flag_reg` to zero, including in a cycle where a valid legal operation is presented.
- R10: For codes 5, 6 and 7, `res_out` and `flag_now` are zero and `flag_reg` keeps its value even with `op_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_valid | input | 1 | Qualifies the current operation for a flag-register load |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5-7 reserved |
| a_in | input | W (16) | First operand (minuend for subtraction) |
| b_in | input | W (16) | Second operand (subtrahend for subtraction) |
| res_out | output | W (16) | Combinational result |
| flag_now | output | 6 | Combinational flags {overflow, sign, zero, nibble carry, parity, carry} from bit 5 down to bit 0 |
| flag_reg | output | 6 | Registered flags, same bit layout as `flag_now` |

## Verification
Two things can fall in the same cycle. One is the capture of one operation's flags into the register while the next operation's flags already show on `flag_now`. The other is a reset that arrives together with a valid load. The bench presents back-to-back valid operations whose flag patterns differ and checks `flag_reg` one edge later against the earlier operation's model value, not the current one. It also asserts reset in a cycle that carries a valid add which would set carry, zero, nibble carry and parity, and it expects the register to read all zeros afterwards.

// File: rtl/afg_pkg.sv
package afg_pkg;

    localparam int NFLAG = 6;

    // flag bit positions inside the six-bit condition word
    localparam int FB_CARRY  = 0;
    localparam int FB_PARITY = 1;
    localparam int FB_NIBBLE = 2;
    localparam int FB_ZERO   = 3;
    localparam int FB_SIGN   = 4;
    localparam int FB_OVF    = 5;

    typedef enum logic [2:0] {
        OPC_ADD = 3'd0,
        OPC_SUB = 3'd1,
        OPC_AND = 3'd2,
        OPC_OR  = 3'd3,
        OPC_XOR = 3'd4
    } afg_op_e;

    typedef logic [NFLAG-1:0] afg_flags_t;

endpackage

// File: rtl/afg_arith.sv
module afg_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry_fl,
    output logic         nibble_fl,
    output logic         ovf_fl
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;
    logic [4:0]   low_nib;

    always_comb begin
        b_eff   = do_sub ? ~opb : opb;
        wide    = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        low_nib = {1'b0, opa[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, do_sub};
        sum     = wide[W-1:0];
        // a subtract reports borrow, the inverse of the adder carry
        carry_fl  = do_sub ? ~wide[W] : wide[W];
        nibble_fl = do_sub ? ~low_nib[4] : low_nib[4];
        ovf_fl    = (opa[W-1] == b_eff[W-1]) && (wide[W-1] != opa[W-1]);
    end
endmodule

// File: rtl/afg_logic.sv
module afg_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   fsel,
    output logic [W-1:0] lres
);
    always_comb begin
        unique case (fsel)
            2'd0:    lres = opa & opb;
            2'd1:    lres = opa | opb;
            default: lres = opa ^ opb;
        endcase
    end
endmodule

// File: rtl/afg_flag_eval.sv
module afg_flag_eval #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    output logic         sign_fl,
    output logic         zero_fl,
    output logic         par_fl
);
    localparam int PB = (W < 8) ? W : 8;

    always_comb begin
        sign_fl = value[W-1];
        zero_fl = (value == '0);
        par_fl  = ~^value[PB-1:0];
    end
endmodule

// File: rtl/afg_core.sv
module afg_core
    import afg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] res_out,
    output logic [5:0]   flag_now,
    output logic [5:0]   flag_reg
);
    logic [W-1:0] arith_sum, logic_res, mux_res;
    logic         a_carry, a_nib, a_ovf;
    logic         e_sign, e_zero, e_par;
    logic         is_arith, is_logic, is_legal;
    logic [1:0]   lsel;
    afg_flags_t   flags_d, flags_q;

    always_comb begin
        is_arith = (op_sel == OPC_ADD) || (op_sel == OPC_SUB);
        is_logic = (op_sel == OPC_AND) || (op_sel == OPC_OR) || (op_sel == OPC_XOR);
        is_legal = is_arith || is_logic;
        lsel     = (op_sel == OPC_AND) ? 2'd0 : (op_sel == OPC_OR) ? 2'd1 : 2'd2;
    end

    afg_arith #(.W(W)) u_arith (
        .opa(a_in), .opb(b_in), .do_sub(op_sel == OPC_SUB),
        .sum(arith_sum), .carry_fl(a_carry), .nibble_fl(a_nib), .ovf_fl(a_ovf)
    );

    afg_logic #(.W(W)) u_logic (
        .opa(a_in), .opb(b_in), .fsel(lsel), .lres(logic_res)
    );

    always_comb begin
        if (is_arith)      mux_res = arith_sum;
        else if (is_logic) mux_res = logic_res;
        else               mux_res = '0;
    end

    afg_flag_eval #(.W(W)) u_eval (
        .value(mux_res), .sign_fl(e_sign), .zero_fl(e_zero), .par_fl(e_par)
    );

    always_comb begin
        flags_d = '0;
        if (is_legal) begin
            flags_d[FB_SIGN]   = e_sign;
            flags_d[FB_ZERO]   = e_zero;
            flags_d[FB_PARITY] = e_par;
            if (is_arith) begin
                flags_d[FB_CARRY]  = a_carry;
                flags_d[FB_NIBBLE] = a_nib;
                flags_d[FB_OVF]    = a_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    flags_q <= '0;
        else if (op_valid && is_legal) flags_q <= flags_d;
    end

    assign res_out  = mux_res;
    assign flag_now = flags_d;
    assign flag_reg = flags_q;
endmodule

// File: rtl/afg_chk.sv
module afg_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [2:0]   op_sel,
    input logic [W-1:0] res_out,
    input logic [5:0]   flag_now,
    input logic [5:0]   flag_reg
);
    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= 3'd4) |=> (flag_reg == $past(flag_now)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flag_reg));

    // R10
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'd4) |=> $stable(flag_reg));

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'd4) |-> (res_out == '0 && flag_now == 6'd0));

    // R2
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 3'd2 && op_sel <= 3'd4) |-> (flag_now[0] == 1'b0 && flag_now[2] == 1'b0 && flag_now[5] == 1'b0));

    // R5
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel <= 3'd4) |-> (flag_now[3] == (res_out == '0)));
endmodule

bind afg_core afg_chk #(.W(W)) u_afg_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .res_out(res_out), .flag_now(flag_now), .flag_reg(flag_reg)
);

// File: tb/tb_afg_core.sv
module tb_afg_core;
    localparam int W = 16;
    localparam int NV = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [2:0]   op_sel = 3'd0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] res_out;
    logic [5:0]   flag_now, flag_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    afg_core #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .a_in(a_in), .b_in(b_in), .res_out(res_out),
        .flag_now(flag_now), .flag_reg(flag_reg)
    );

    // {opcode, a, b, expected result}
    localparam logic [50:0] VEC [NV] = '{
        {3'd0, 16'h0001, 16'h0001, 16'h0002},
        {3'd0, 16'hFFFF, 16'h0001, 16'h0000},
        {3'd0, 16'h7FFF, 16'h0001, 16'h8000},
        {3'd0, 16'h8000, 16'h8000, 16'h0000},
        {3'd1, 16'h0005, 16'h0007, 16'hFFFE},
        {3'd1, 16'h8000, 16'h0001, 16'h7FFF},
        {3'd1, 16'h1234, 16'h1234, 16'h0000},
        {3'd1, 16'h0010, 16'h0001, 16'h000F},
        {3'd2, 16'hF0F0, 16'h3C3C, 16'h3030},
        {3'd3, 16'h0F00, 16'h00F0, 16'h0FF0},
        {3'd4, 16'hAAAA, 16'hAAAB, 16'h0001},
        {3'd4, 16'h8000, 16'h0000, 16'h8000},
        {3'd0, 16'h000F, 16'h0001, 16'h0010}
    };

    function automatic logic [5:0] model_flags(input logic [2:0] op,
                                               input logic [15:0] a, input logic [15:0] b);
        logic [5:0]  f;
        logic [15:0] r;
        int sa, sb, sr, ones;
        f  = '0;
        sa = a[15] ? int'(a) - 65536 : int'(a);
        sb = b[15] ? int'(b) - 65536 : int'(b);
        case (op)
            3'd0: begin
                r = a + b;
                f[0] = (int'(a) + int'(b)) > 65535;
                f[2] = (int'(a[3:0]) + int'(b[3:0])) > 15;
                sr = sa + sb;
                f[5] = (sr > 32767) || (sr < -32768);
            end
            3'd1: begin
                r = a - b;
                f[0] = a < b;
                f[2] = a[3:0] < b[3:0];
                sr = sa - sb;
                f[5] = (sr > 32767) || (sr < -32768);
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            default: r = '0;
        endcase
        if (op <= 3'd4) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += int'(r[i]);
            f[4] = r[15];
            f[3] = (r == 16'h0000);
            f[1] = (ones % 2) == 0;
        end
        return f;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic present(input logic v, input logic [2:0] op,
                           input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_valid = v; op_sel = op; a_in = a; b_in = b;
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [5:0] prev_exp;
        logic [5:0] e;
        // R9: register is zero while reset is held
        repeat (2) @(posedge clk);
        #1 check("R9 reset value", {10'd0, flag_reg}, 16'd0);
        @(negedge clk) rst_n = 1'b1;

        // table walk: R1..R7 combinational, R8 capture one edge later
        prev_exp = '0;
        for (int k = 0; k < NV; k++) begin
            logic [2:0]  op;
            logic [15:0] va, vb, vr;
            {op, va, vb, vr} = VEC[k];
            present(1'b1, op, va, vb);
            // R8: register still holds the previous operation's flags
            check("R8 before edge", {10'd0, flag_reg}, {10'd0, prev_exp});
            check("R1 result", res_out, vr);
            e = model_flags(op, va, vb);
            check("R2 carry", {15'd0, flag_now[0]}, {15'd0, e[0]});
            check("R3 overflow", {15'd0, flag_now[5]}, {15'd0, e[5]});
            check("R4 sign", {15'd0, flag_now[4]}, {15'd0, e[4]});
            check("R5 zero", {15'd0, flag_now[3]}, {15'd0, e[3]});
            check("R6 nibble", {15'd0, flag_now[2]}, {15'd0, e[2]});
            check("R7 parity", {15'd0, flag_now[1]}, {15'd0, e[1]});
            prev_exp = e;
        end
        @(posedge clk); #1;
        check("R8 last capture", {10'd0, flag_reg}, {10'd0, prev_exp});

        // R8: valid low leaves register unchanged while flag_now shows new op
        present(1'b0, 3'd1, 16'h0000, 16'h0001);
        check("R8 idle flag_now", {10'd0, flag_now}, {10'd0, model_flags(3'd1, 16'h0000, 16'h0001)});
        @(posedge clk); #1;
        check("R8 hold on idle", {10'd0, flag_reg}, {10'd0, prev_exp});

        // R10: reserved codes with valid high
        for (int c = 5; c < 8; c++) begin
            present(1'b1, 3'(c), 16'h1234, 16'h4321);
            check("R10 reserved result", res_out, 16'h0000);
            check("R10 reserved flags", {10'd0, flag_now}, 16'd0);
            @(posedge clk); #1;
            check("R10 reserved no load", {10'd0, flag_reg}, {10'd0, prev_exp});
        end

        // R9: reset coinciding with a valid load that would set many flags
        present(1'b1, 3'd0, 16'hFFFF, 16'h0001);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9 reset beats load", {10'd0, flag_reg}, 16'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R8 load after reset", {10'd0, flag_reg}, {10'd0, model_flags(3'd0, 16'hFFFF, 16'h0001)});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule